// File: doc/BRIEF.md
# SPI Slave Framed Packet Endpoint

This block is an SPI slave (mode 0, eight-bit transfers, most significant bit first) that puts a length-prefixed framing layer on top of a full-duplex link. The host is half-duplex. Every transfer still shifts a byte into the slave, including the bytes the host clocks while it only wants to read. The receive parser therefore watches the MOSI byte stream for the start marker 0xFE. The byte after the marker is a one-byte length, and that many payload bytes are then handed downstream. Every other byte is thrown away.

A frame whose length is zero is a read request. The transmit sequencer answers it on MISO with 0xFE, then a byte holding the number of bytes that were waiting in its transmit FIFO at that moment (capped at 255), then exactly those bytes in the order they were pushed. When no answer is pending, MISO carries 0x00.

The receive and transmit paths run independently of each other. Chip select, SCLK and MOSI are resynchronised into the system clock, which must run at least four times faster than SCLK.

The receive output is a valid/ready stream. SPI cannot stall, so a held byte must be accepted within one byte time (eight SCLK periods). The transmit FIFO input is a valid/ready stream: a byte is stored on a clock where both valid and ready are high, and ready is low while the FIFO is full.

Top module: `spi_frame_endpoint`

## Requirements
- R1: With no response armed, and again after a response has been fully sent, MISO shifts out 0x00 bytes.
- R2: While hunting, every received byte other than 0xFE is discarded and produces no output. This includes filler clocked in during host reads.
- R3: The byte after 0xFE is a length L. The next L bytes, whatever their value, are delivered in order on the receive stream. `rx_first` marks the first of them and `rx_last` marks the L-th. The parser then hunts again.
- R4: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold.
- R5: A frame with L = 0 delivers nothing and arms a response. The response header is 0xFE followed by N, where N is the FIFO occupancy at the request, capped at 255.
- R6: After the header, exactly N bytes are popped from the FIFO and sent in push order.
- R7: Raising chip select before a frame completes returns the parser to hunting. If it happens during the payload, `rx_abort` pulses for one clock.
- R8: `tx_ready` is low exactly when the transmit FIFO holds FIFO_DEPTH bytes.
- R9: A frame received while a response is being sent is parsed and delivered normally.
- R10: Bits are sampled on the rising SCLK edge and MISO changes after the falling edge, most significant bit first. The first bit of a byte is valid within half an SCLK period after chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rx_valid | output | 1 | Received payload byte available |
| rx_ready | input | 1 | Downstream accepts the byte |
| rx_data | output | 8 | Payload byte |
| rx_first | output | 1 | Byte is first of its frame |
| rx_last | output | 1 | Byte is last of its frame |
| rx_abort | output | 1 | One-clock pulse: payload cut short by chip select |
| tx_valid | input | 1 | Byte offered to transmit FIFO |
| tx_ready | output | 1 | Transmit FIFO has room |
| tx_data | input | 8 | Byte to queue for the host |

## Verification
The assertions assume three things about the inputs. SCLK toggles only while chip select is low, and slowly enough that two synchronised edges never fall in the same clock. Chip select changes only while SCLK is low. Downstream accepts a held receive byte before the next one completes. The bench drives SCLK with a half period of six clocks, and it moves chip select only after SCLK has settled low. Its random `rx_ready` is high three clocks in four, so any stall stays far below a byte time. The stall test holds ready low only across a single one-byte frame.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SOF_BYTE = 8'hFE;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h00;

  typedef enum logic [1:0] {RX_HUNT, RX_LEN, RX_PAY} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_HSOF, TX_HLEN, TX_PAY} tx_state_t;
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              cs_rise
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic sclk_p, cs_p;
  logic sclk_s, cs_s, mosi_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];

  // synchroniser chains plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sclk_p <= sclk_s;
      cs_p   <= cs_s;
    end
  end

  logic sclk_rise, sclk_fall, cs_fall;
  assign sclk_rise = sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s & sclk_p;
  assign cs_fall   = ~cs_s & cs_p;
  assign cs_rise   = cs_s & ~cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_sh   <= tx_byte;
      end else if (!cs_s) begin
        if (sclk_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W-1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[BYTE_W-2:0], mosi_s};
          end
        end else if (sclk_fall) begin
          if (bit_cnt == '0) tx_sh <= tx_byte;
          else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end else begin
        bit_cnt <= '0;
      end
    end
  end

  assign miso = tx_sh[BYTE_W-1] & ~cs_s;

  // R10: a byte can only complete while the slave was selected
  a_r10_done_selected: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(!cs_s));
endmodule

// File: rtl/spi_frame_rx_parser.sv
module spi_frame_rx_parser
  import spi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              cs_rise,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              rx_last,
  output logic              rx_abort,
  output logic              rd_req
);
  rx_state_t         state;
  logic [BYTE_W-1:0] remain;
  logic              first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_HUNT;
      remain     <= '0;
      first_pend <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_first   <= 1'b0;
      rx_last    <= 1'b0;
      rx_abort   <= 1'b0;
      rd_req     <= 1'b0;
    end else begin
      rd_req   <= 1'b0;
      rx_abort <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (cs_rise) begin
        if (state == RX_PAY) rx_abort <= 1'b1;
        state <= RX_HUNT;
      end else if (byte_done) begin
        unique case (state)
          RX_HUNT: if (rx_byte == SOF_BYTE) state <= RX_LEN;
          RX_LEN: begin
            if (rx_byte == '0) begin
              rd_req <= 1'b1;
              state  <= RX_HUNT;
            end else begin
              remain     <= rx_byte;
              first_pend <= 1'b1;
              state      <= RX_PAY;
            end
          end
          RX_PAY: begin
            rx_valid   <= 1'b1;
            rx_data    <= rx_byte;
            rx_first   <= first_pend;
            rx_last    <= (remain == BYTE_W'(1));
            first_pend <= 1'b0;
            remain     <= remain - 1'b1;
            if (remain == BYTE_W'(1)) state <= RX_HUNT;
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort);
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r3_no_pay_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == RX_HUNT) |=> !$rose(rx_valid));
endmodule

// File: rtl/spi_frame_tx_seq.sv
module spi_frame_tx_seq
  import spi_frame_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rd_req,
  input  logic              byte_done,
  output logic [BYTE_W-1:0] tx_byte
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [BYTE_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  tx_state_t         state;
  logic [BYTE_W-1:0] hdr_len, remain;
  logic              push, pop;

  assign tx_ready = (32'(count) < FIFO_DEPTH);
  assign push     = tx_valid && tx_ready;
  assign pop      = (state == TX_PAY) && byte_done;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (32'(wr_ptr) == FIFO_DEPTH - 1) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (32'(rd_ptr) == FIFO_DEPTH - 1) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      hdr_len <= '0;
      remain  <= '0;
    end else begin
      unique case (state)
        TX_IDLE: if (rd_req) begin
          hdr_len <= (32'(count) > 255) ? 8'hFF : 8'(count);
          state   <= TX_HSOF;
        end
        TX_HSOF: if (byte_done) state <= TX_HLEN;
        TX_HLEN: if (byte_done) begin
          remain <= hdr_len;
          state  <= (hdr_len == '0) ? TX_IDLE : TX_PAY;
        end
        TX_PAY: if (byte_done) begin
          remain <= remain - 1'b1;
          if (remain == BYTE_W'(1)) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      TX_HSOF: tx_byte = SOF_BYTE;
      TX_HLEN: tx_byte = hdr_len;
      TX_PAY:  tx_byte = mem[rd_ptr];
      default: tx_byte = IDLE_BYTE;
    endcase
  end

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  a_r6_remain_backed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_PAY) |-> (32'(remain) <= 32'(count)));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (32'(count) <= FIFO_DEPTH));
  a_r5_arm_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && state == TX_IDLE) |=> (state == TX_HSOF));
endmodule

// File: rtl/spi_frame_endpoint.sv
module spi_frame_endpoint
  import spi_frame_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_first,
  output logic       rx_last,
  output logic       rx_abort,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data
);
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic byte_done, cs_rise, rd_req;

  spi_frame_shifter #(.SYNC_STAGES(SYNC_STAGES)) shifter_i (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .miso(spi_miso), .rx_byte(rx_byte),
    .byte_done(byte_done), .cs_rise(cs_rise)
  );

  spi_frame_rx_parser parser_i (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_rise(cs_rise), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .rx_last(rx_last),
    .rx_abort(rx_abort), .rd_req(rd_req)
  );

  spi_frame_tx_seq #(.FIFO_DEPTH(FIFO_DEPTH)) txseq_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rd_req(rd_req), .byte_done(byte_done),
    .tx_byte(tx_byte)
  );
endmodule

// File: tb/spi_frame_endpoint_tb.sv
module spi_frame_endpoint_tb_top;
  localparam int DEPTH = 16;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic rx_valid, rx_ready = 1'b1, rx_first, rx_last, rx_abort;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;

  always #2 clk = ~clk;

  spi_frame_endpoint #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_first(rx_first), .rx_last(rx_last), .rx_abort(rx_abort),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  int n_chk = 0, n_bad = 0, abort_seen = 0, abort_exp = 0;
  bit done = 1'b0, stall = 1'b0;
  logic [9:0] exp_q[$];
  logic [7:0] model_fifo[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hdr_len(input int n);
    return (n > 255) ? 8'hFF : 8'(n);
  endfunction

  function automatic logic [7:0] filler();
    return 8'($urandom % 254);
  endfunction

  // receive monitor: ready chosen first, then the handshake it implies is checked
  always @(negedge clk) begin
    if (rst_n) begin
      rx_ready = stall ? 1'b0 : (($urandom % 4) != 0);
      if (rx_abort) abort_seen++;
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected rx byte", int'({rx_first, rx_last, rx_data}), 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({rx_first, rx_last, rx_data} == e, "R3", "rx first/last/data",
                int'({rx_first, rx_last, rx_data}), int'(e));
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] ob, output logic [7:0] ib);
    for (int i = 7; i >= 0; i--) begin
      mosi = ob[i];
      repeat (HALF) @(negedge clk);
      ib[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk); cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_frame(input int len);
    logic [7:0] d, b;
    xfer(8'hFE, d);
    xfer(8'(len), d);
    for (int i = 0; i < len; i++) begin
      b = 8'($urandom);
      exp_q.push_back({(i == 0), (i == len - 1), b});
      xfer(b, d);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    model_fifo.push_back(b);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // zero-length request, then a read that also may carry a frame (R9)
  task automatic do_read(input int frame_len);
    logic [7:0] d, e;
    int n;
    cs_lo(); xfer(8'hFE, d); xfer(8'h00, d); cs_hi();
    n = model_fifo.size();
    cs_lo();
    if (frame_len > 0) begin
      xfer(8'hFE, d);
      check(d == 8'hFE, "R5", "header sof", d, 8'hFE);
      xfer(8'(frame_len), d);
    end else begin
      xfer(filler(), d);
      check(d == 8'hFE, "R5", "header sof", d, 8'hFE);
      xfer(filler(), d);
    end
    check(d == exp_hdr_len(n), "R5", "header length", d, exp_hdr_len(n));
    for (int i = 0; i < n; i++) begin
      logic [7:0] ob;
      if (i < frame_len) begin
        ob = 8'($urandom);
        exp_q.push_back({(i == 0), (i == frame_len - 1), ob});
      end else ob = filler();
      xfer(ob, d);
      e = model_fifo.pop_front();
      check(d == e, "R6", "payload byte", d, e);
    end
    xfer(filler(), d);
    check(d == 8'h00, "R1", "idle after response", d, 0);
    cs_hi();
  endtask

  initial begin
    int seed;
    logic [7:0] d;
    seed = $urandom(32'h5EED);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_valid == 1'b0, "R3", "reset rx_valid", rx_valid, 0);
    check(tx_ready == 1'b1, "R8", "reset tx_ready", tx_ready, 1);
    check(miso == 1'b0, "R1", "reset miso", miso, 0);

    // R1: nothing armed
    cs_lo(); xfer(8'h11, d); check(d == 8'h00, "R1", "idle miso", d, 0);
    xfer(8'h22, d); check(d == 8'h00, "R1", "idle miso", d, 0); cs_hi();

    // R2/R3: junk ahead of frame, payload containing SOF value
    cs_lo(); xfer(8'h37, d); xfer(8'h00, d); xfer(8'h03, d);
    xfer(8'hFE, d); xfer(8'h03, d);
    exp_q.push_back({2'b10, 8'hFE}); xfer(8'hFE, d);
    exp_q.push_back({2'b00, 8'h55}); xfer(8'h55, d);
    exp_q.push_back({2'b01, 8'hFE}); xfer(8'hFE, d);
    xfer(8'h04, d); xfer(8'h99, d); cs_hi();

    // R4: stall across one-byte frame
    stall = 1'b1;
    cs_lo(); xfer(8'hFE, d); xfer(8'h01, d); xfer(8'hA5, d); cs_hi();
    check(rx_valid == 1'b1, "R4", "stalled valid", rx_valid, 1);
    check(rx_data == 8'hA5, "R4", "stalled data", rx_data, 8'hA5);
    repeat (20) @(negedge clk);
    check(rx_valid && rx_data == 8'hA5, "R4", "held data", rx_data, 8'hA5);
    exp_q.push_back({2'b11, 8'hA5});
    stall = 1'b0;

    // random frames with junk
    for (int k = 0; k < 20; k++) begin
      cs_lo();
      for (int j = 0; j < int'($urandom % 4); j++) xfer(filler(), d);
      send_frame(1 + int'($urandom % 6));
      cs_hi();
    end

    // R5/R6: empty response, then random fills
    do_read(0);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 1 + int'($urandom % 6); j++) push(8'($urandom));
      do_read(0);
    end

    // R9: frame carried in the read transaction
    for (int j = 0; j < 6; j++) push(8'($urandom));
    do_read(3);

    // R8: full FIFO
    for (int j = 0; j < DEPTH; j++) push(8'($urandom));
    @(negedge clk);
    check(tx_ready == 1'b0, "R8", "full tx_ready", tx_ready, 0);
    do_read(0);
    check(tx_ready == 1'b1, "R8", "drained tx_ready", tx_ready, 1);

    // R7: abort in payload, then unframed bytes must be ignored
    cs_lo(); xfer(8'hFE, d); xfer(8'h05, d);
    exp_q.push_back({2'b10, 8'h61}); xfer(8'h61, d);
    exp_q.push_back({2'b00, 8'h62}); xfer(8'h62, d);
    cs_hi(); abort_exp++;
    cs_lo(); xfer(8'h02, d); xfer(8'hAA, d); xfer(8'hBB, d); cs_hi();
    check(abort_seen == abort_exp, "R7", "payload abort count", abort_seen, abort_exp);
    // R7: abort in length state: no pulse, hunt resumes
    cs_lo(); xfer(8'hFE, d); cs_hi();
    cs_lo(); xfer(8'h01, d); xfer(8'h77, d); cs_hi();
    check(abort_seen == abort_exp, "R7", "length abort no pulse", abort_seen, abort_exp);
    cs_lo(); send_frame(2); cs_hi();

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R3", "all payload delivered", exp_q.size(), 0);
    check(abort_seen == abort_exp, "R7", "final abort count", abort_seen, abort_exp);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule